// File: doc/BRIEF.md
# Paired-Channel ADC Acquisition Sequencer

This block runs two external analog-to-digital converters side by side. Each converter supplies one channel of a channel pair. On every pacing tick the sequencer asks the converter front end to convert the current pair. When the front end reports completion, the sequencer writes both results into a sample FIFO, lower channel first, and moves on to the next pair. After the highest programmed pair it goes back to pair 0.

Software controls the block through three write-only registers. One is a control word; the other two hold the two parts of a 24-bit pacing period. Acquisition starts when software sets the run bit, or when a falling edge arrives on an external trigger pin while triggering is enabled. It stops when software clears the run bit, or by itself when the FIFO reports full. The block reaches the FIFO only through push, full and clear signals. The converter front end is abstracted to a request/done handshake that carries the pair number, the input range and the differential-mode flag.

Top module: `pair_adc_sequencer`

## Requirements
- R1: While rst is high, and on the cycle after it, running, conv_req, fifo_push and fifo_clear are all low.
- R2: Address 0 holds the control word. Writing it with bit 0 (run) set while stopped raises running on the second rising clock edge after the write cycle. The same write captures the other control fields for the run.
- R3: Control bit 1 enables the trigger. With it set, a falling edge on ext_trig_n, seen through a two-flop synchronizer, starts acquisition while stopped. With it clear, edges on ext_trig_n do not start acquisition.
- R4: Control bits 5:2 hold the highest pair number. Pairs are converted in the order 0, 1, up to that number, then from 0 again, and conv_pair never exceeds it.
- R5: The pacing period P is formed as {address 1 bits 7:0, address 2 bits 15:0}, and P = 0 acts as 1. The first conv_req comes P cycles after running rises. Later requests follow every P cycles as long as each conversion and its two pushes fit within P.
- R6: conv_req is a one-cycle pulse and is never issued while a conversion is outstanding. Ticks that arrive during a conversion collapse into one pending request. That request is issued on the cycle after the second push, so a converter that raises conv_done L cycles after the request cycle gives a request spacing of L+4 whenever L+4 > P.
- R7: Each finished conversion gives two pushes in consecutive cycles. The first carries conv_res_a with fifo_chan = 2*pair. The second carries conv_res_b with fifo_chan = 2*pair+1. fifo_chan is 5 bits wide.
- R8: Writing the control word with run clear stops acquisition. running falls, and no conv_req or fifo_push occurs until the next start.
- R9: No push happens in a cycle after one in which fifo_full was high. When the sequencer sees fifo_full it stops and running falls.
- R10: A control write whose bits 9:1 differ from the stored ones pulses fifo_clear for one cycle. If acquisition is running, it keeps running with the new settings, any conversion in flight is abandoned, and the next sample pushed is channel 0. A control write with unchanged bits 9:1 produces no clear and leaves the sequence undisturbed.
- R11: conv_range carries control bits 7:6 and conv_diff carries the OR of control bits 9:8, as captured at start or at the last reconfiguration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Register address: 0 control, 1 pacing upper, 2 pacing lower |
| reg_wr_data | input | 16 | Register write data |
| ext_trig_n | input | 1 | Asynchronous external trigger, falling edge starts acquisition |
| conv_req | output | 1 | One-cycle conversion request to the front end |
| conv_pair | output | 4 | Pair number for the requested conversion |
| conv_range | output | 2 | Captured input range code |
| conv_diff | output | 1 | Captured differential-mode flag |
| conv_done | input | 1 | Front end reports both results valid |
| conv_res_a | input | 16 | Result from the first converter (even channel) |
| conv_res_b | input | 16 | Result from the second converter (odd channel) |
| fifo_push | output | 1 | Write one sample into the FIFO |
| fifo_data | output | 16 | Sample value |
| fifo_chan | output | 5 | Channel number of the sample |
| fifo_full | input | 1 | FIFO holds its maximum count |
| fifo_clear | output | 1 | Flush the FIFO |
| running | output | 1 | Acquisition is active |

## Verification
The bench goes after pair wrap-around with a small pair limit. A design that miscounted the limit would push channels past the limit or skip pair 0. It measures the first request delay and the request spacing, once with a period above 16 bits, where an off-by-one pacer or a wrongly joined 24-bit period shows up as a wrong cycle count. A slow converter model checks that ticks are held rather than overlapped or queued: overlapping would issue a request before conv_done, and counting ticks would change the spacing. Reconfiguration during a run, a rewrite with unchanged contents, the trigger with its enable both off and on, and FIFO full are each checked separately. A sequencer that failed to flush would keep pushing the old pair numbers, and one that ignored full would keep pushing.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_BUSY,
    ST_PUSH_A,
    ST_PUSH_B
  } seq_state_t;

  localparam logic [1:0] ADDR_CTRL    = 2'd0;
  localparam logic [1:0] ADDR_PACE_HI = 2'd1;
  localparam logic [1:0] ADDR_PACE_LO = 2'd2;
endpackage

// File: rtl/seq_edge_sync.sv
module seq_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic fall
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= pin_n;
      s2 <= s1;
      s3 <= s2;
    end
  end

  // s3 is the previous synchronized level
  assign fall = s3 & ~s2;
endmodule

// File: rtl/seq_pacer.sv
module seq_pacer #(
  parameter int PACE_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              restart,
  input  logic [PACE_W-1:0] period,
  output logic              tick
);
  logic [PACE_W-1:0] cnt;
  logic [PACE_W-1:0] last;

  assign last = (period == '0) ? '0 : period - PACE_W'(1);

  always_ff @(posedge clk) begin
    if (rst || restart || !enable) cnt <= '0;
    else if (cnt >= last)          cnt <= '0;
    else                           cnt <= cnt + PACE_W'(1);
  end

  assign tick = enable && !restart && (cnt >= last);
endmodule

// File: rtl/seq_host_regs.sv
module seq_host_regs
  import seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PAIR_W = 4,
  parameter int PACE_W = 24,
  parameter int PACE_RST = 320
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              trig_en,
  output logic [PAIR_W-1:0] max_pair,
  output logic [1:0]        range,
  output logic              diff,
  output logic [PACE_W-1:0] pace,
  output logic              ctrl_wr,
  output logic              run_val,
  output logic              cfg_chg
);
  localparam int TRIG_BIT  = 1;
  localparam int MAX_LSB   = 2;
  localparam int RANGE_LSB = MAX_LSB + PAIR_W;
  localparam int DIFF_LSB  = RANGE_LSB + 2;
  localparam int CFG_TOP   = DIFF_LSB + 1;
  localparam int CFG_W     = CFG_TOP;
  localparam int HI_W      = PACE_W - DATA_W;

  logic [CFG_W-1:0]  cfg_q;     // control bits CFG_TOP:1
  logic [HI_W-1:0]   pace_hi;
  logic [DATA_W-1:0] pace_lo;
  logic [CFG_W-1:0]  cfg_new;
  logic              unused_bits;

  assign cfg_new     = wr_data[CFG_TOP:1];
  assign unused_bits = ^{wr_data[DATA_W-1:CFG_TOP+1], wr_data[DATA_W-1:HI_W]};

  always_ff @(posedge clk) begin
    ctrl_wr <= 1'b0;
    cfg_chg <= 1'b0;
    if (rst) begin
      cfg_q   <= '0;
      run_val <= 1'b0;
      pace_hi <= HI_W'(PACE_RST >> DATA_W);
      pace_lo <= DATA_W'(PACE_RST);
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_CTRL: begin
          ctrl_wr <= 1'b1;
          run_val <= wr_data[0];
          cfg_chg <= (cfg_new != cfg_q);
          cfg_q   <= cfg_new;
        end
        ADDR_PACE_HI: pace_hi <= wr_data[HI_W-1:0];
        ADDR_PACE_LO: pace_lo <= wr_data;
        default: ;
      endcase
    end
  end

  assign trig_en  = cfg_q[TRIG_BIT-1];
  assign max_pair = cfg_q[MAX_LSB-1 +: PAIR_W];
  assign range    = cfg_q[RANGE_LSB-1 +: 2];
  assign diff     = |cfg_q[DIFF_LSB-1 +: 2];
  assign pace     = {pace_hi, pace_lo};
endmodule

// File: rtl/pair_adc_sequencer.sv
module pair_adc_sequencer
  import seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PAIR_W = 4,
  parameter int PACE_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_wr_addr,
  input  logic [DATA_W-1:0] reg_wr_data,
  input  logic              ext_trig_n,
  output logic              conv_req,
  output logic [PAIR_W-1:0] conv_pair,
  output logic [1:0]        conv_range,
  output logic              conv_diff,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_res_a,
  input  logic [DATA_W-1:0] conv_res_b,
  output logic              fifo_push,
  output logic [DATA_W-1:0] fifo_data,
  output logic [PAIR_W:0]   fifo_chan,
  input  logic              fifo_full,
  output logic              fifo_clear,
  output logic              running
);
  localparam int CHAN_W = PAIR_W + 1;

  logic              cfg_trig_en, cfg_diff, ctrl_wr, run_val, cfg_chg;
  logic [PAIR_W-1:0] cfg_max;
  logic [1:0]        cfg_range;
  logic [PACE_W-1:0] pace;
  logic              trig_fall, tick;
  logic              start_evt, stop_evt, flush_evt;

  seq_state_t        state;
  logic              pend_q;
  logic [PAIR_W-1:0] pair_q, run_max;
  logic [1:0]        run_range;
  logic              run_diff;
  logic [DATA_W-1:0] res_a, res_b;

  seq_host_regs #(.DATA_W(DATA_W), .PAIR_W(PAIR_W), .PACE_W(PACE_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wr_addr(reg_wr_addr),
    .wr_data(reg_wr_data), .trig_en(cfg_trig_en), .max_pair(cfg_max),
    .range(cfg_range), .diff(cfg_diff), .pace(pace), .ctrl_wr(ctrl_wr),
    .run_val(run_val), .cfg_chg(cfg_chg)
  );

  seq_edge_sync u_trig (
    .clk(clk), .rst(rst), .pin_n(ext_trig_n), .fall(trig_fall)
  );

  assign start_evt = !running && ((ctrl_wr && run_val) || (trig_fall && cfg_trig_en));
  assign stop_evt  = running && ctrl_wr && !run_val;
  assign flush_evt = running && cfg_chg && !stop_evt;

  seq_pacer #(.PACE_W(PACE_W)) u_pacer (
    .clk(clk), .rst(rst), .enable(running),
    .restart(start_evt || flush_evt), .period(pace), .tick(tick)
  );

  always_ff @(posedge clk) begin
    conv_req   <= 1'b0;
    fifo_push  <= 1'b0;
    fifo_clear <= cfg_chg;
    if (rst) begin
      state      <= ST_IDLE;
      running    <= 1'b0;
      pend_q     <= 1'b0;
      pair_q     <= '0;
      conv_pair  <= '0;
      run_max    <= '0;
      run_range  <= '0;
      run_diff   <= 1'b0;
      res_a      <= '0;
      res_b      <= '0;
      fifo_data  <= '0;
      fifo_chan  <= '0;
      fifo_clear <= 1'b0;
    end else if (stop_evt) begin
      state   <= ST_IDLE;
      running <= 1'b0;
      pend_q  <= 1'b0;
    end else if (start_evt || flush_evt) begin
      running   <= 1'b1;
      state     <= ST_WAIT;
      pend_q    <= 1'b0;
      pair_q    <= '0;
      run_max   <= cfg_max;
      run_range <= cfg_range;
      run_diff  <= cfg_diff;
    end else begin
      if (tick && state != ST_WAIT) pend_q <= 1'b1;
      unique case (state)
        ST_WAIT: begin
          if (fifo_full) begin
            state   <= ST_IDLE;
            running <= 1'b0;
            pend_q  <= 1'b0;
          end else if (tick || pend_q) begin
            conv_req  <= 1'b1;
            conv_pair <= pair_q;
            pend_q    <= 1'b0;
            state     <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          if (conv_done) begin
            res_a <= conv_res_a;
            res_b <= conv_res_b;
            state <= ST_PUSH_A;
          end
        end
        ST_PUSH_A: begin
          if (fifo_full) begin
            state   <= ST_IDLE;
            running <= 1'b0;
            pend_q  <= 1'b0;
          end else begin
            fifo_push <= 1'b1;
            fifo_data <= res_a;
            fifo_chan <= CHAN_W'({pair_q, 1'b0});
            state     <= ST_PUSH_B;
          end
        end
        ST_PUSH_B: begin
          if (fifo_full) begin
            state   <= ST_IDLE;
            running <= 1'b0;
            pend_q  <= 1'b0;
          end else begin
            fifo_push <= 1'b1;
            fifo_data <= res_b;
            fifo_chan <= CHAN_W'({pair_q, 1'b1});
            pair_q    <= (pair_q == run_max) ? '0 : pair_q + PAIR_W'(1);
            state     <= ST_WAIT;
          end
        end
        default: ;
      endcase
    end
  end

  assign conv_range = run_range;
  assign conv_diff  = run_diff;
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int PAIR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              conv_req,
  input logic              conv_done,
  input logic [PAIR_W-1:0] conv_pair,
  input logic              fifo_push,
  input logic [PAIR_W:0]   fifo_chan,
  input logic              fifo_full,
  input logic              fifo_clear,
  input logic              running,
  input logic [PAIR_W-1:0] max_run
);
  logic out_q;

  always_ff @(posedge clk) begin
    if (rst) out_q <= 1'b0;
    else if (conv_req) out_q <= 1'b1;
    else if (conv_done || fifo_clear || !running) out_q <= 1'b0;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!running && !conv_req && !fifo_push && !fifo_clear));

  p_req_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    conv_req |=> !conv_req);

  p_no_req_busy_r6: assert property (@(posedge clk) disable iff (rst)
    conv_req |-> !out_q);

  p_pair_bound_r4: assert property (@(posedge clk) disable iff (rst)
    conv_req |-> (conv_pair <= max_run));

  p_full_blocks_push_r9: assert property (@(posedge clk) disable iff (rst)
    fifo_full |=> !fifo_push);

  p_stopped_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !running |-> (!conv_req && !fifo_push));

  p_push_pair_r7: assert property (@(posedge clk) disable iff (rst)
    (fifo_push && !fifo_chan[0]) |=>
      (!running || fifo_clear ||
       (fifo_push && fifo_chan[0] && fifo_chan[PAIR_W:1] == $past(fifo_chan[PAIR_W:1]))));

  p_clear_gap_r10: assert property (@(posedge clk) disable iff (rst)
    fifo_clear |=> !fifo_push);
endmodule

bind pair_adc_sequencer seq_checker #(.PAIR_W(PAIR_W)) u_seq_chk (
  .clk(clk), .rst(rst), .conv_req(conv_req), .conv_done(conv_done),
  .conv_pair(conv_pair), .fifo_push(fifo_push), .fifo_chan(fifo_chan),
  .fifo_full(fifo_full), .fifo_clear(fifo_clear), .running(running),
  .max_run(run_max)
);

// File: tb/pair_adc_sequencer_bench.sv
module pair_adc_sequencer_bench;
  localparam int CLK_P = 10;
  localparam logic [1:0] A_CTRL = 2'd0, A_HI = 2'd1, A_LO = 2'd2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_wr_addr = '0;
  logic [15:0] reg_wr_data = '0;
  logic        ext_trig_n = 1'b1;
  logic        conv_req;
  logic [3:0]  conv_pair;
  logic [1:0]  conv_range;
  logic        conv_diff;
  logic        conv_done = 1'b0;
  logic [15:0] conv_res_a = '0, conv_res_b = '0;
  logic        fifo_push;
  logic [15:0] fifo_data;
  logic [4:0]  fifo_chan;
  logic        fifo_full = 1'b0;
  logic        fifo_clear;
  logic        running;

  always #(CLK_P/2) clk = ~clk;

  pair_adc_sequencer u_pair_adc_sequencer (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .ext_trig_n(ext_trig_n), .conv_req(conv_req),
    .conv_pair(conv_pair), .conv_range(conv_range), .conv_diff(conv_diff),
    .conv_done(conv_done), .conv_res_a(conv_res_a), .conv_res_b(conv_res_b),
    .fifo_push(fifo_push), .fifo_data(fifo_data), .fifo_chan(fifo_chan),
    .fifo_full(fifo_full), .fifo_clear(fifo_clear), .running(running)
  );

  int checks = 0, failures = 0;
  int cyc = 0, npush = 0, nclr = 0, nreq = 0, overlaps = 0;
  int lat = 3, last_req = 0, gap_last = 0;
  bit done_flag = 1'b0;
  logic [20:0] sb_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] word(input int p, input bit b,
                                       input logic [1:0] r, input bit d);
    return {r, d, 1'b0, 4'h0, 4'(p), b ? 4'hB : 4'hA};
  endfunction

  function automatic logic [15:0] ctrl(input bit run, input bit trg, input int mx,
                                       input logic [1:0] r, input logic [1:0] d);
    return {6'b0, d, r, 4'(mx), trg, run};
  endfunction

  // driver: expected pushes for n pairs starting at pair p0
  task automatic expect_seq(input int p0, input int n, input int mx,
                            input logic [1:0] r, input bit d);
    int p = p0;
    for (int i = 0; i < n; i++) begin
      sb_q.push_back({5'(2*p),   word(p, 1'b0, r, d)});
      sb_q.push_back({5'(2*p+1), word(p, 1'b1, r, d)});
      p = (p == mx) ? 0 : p + 1;
    end
  endtask

  // converter front-end model
  int cnt_m = 0;
  bit busy_m = 1'b0;
  always @(negedge clk) begin
    conv_done = 1'b0;
    if (busy_m) begin
      cnt_m--;
      if (cnt_m == 0) begin
        conv_done = 1'b1;
        busy_m = 1'b0;
      end
    end
    if (conv_req) begin
      if (busy_m) overlaps++;
      busy_m = 1'b1;
      cnt_m = lat;
      nreq++;
      gap_last = cyc - last_req;
      last_req = cyc;
      conv_res_a = {conv_range, conv_diff, 1'b0, 4'h0, conv_pair, 4'hA};
      conv_res_b = {conv_range, conv_diff, 1'b0, 4'h0, conv_pair, 4'hB};
    end
  end

  // monitor: scoreboard compare
  always @(negedge clk) begin
    if (fifo_clear) nclr++;
    if (fifo_push) begin
      npush++;
      if (sb_q.size() == 0) begin
        chk(1'b0, "R7", "unexpected push chan", fifo_chan, 0);
      end else begin
        logic [20:0] e;
        e = sb_q.pop_front();
        chk(fifo_chan == e[20:16], "R4/R7", "push channel", fifo_chan, e[20:16]);
        chk(fifo_data == e[15:0], "R7/R11", "push data", fifo_data, e[15:0]);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic wait_pushes(input int n);
    while (npush < n) @(negedge clk);
  endtask

  task automatic wait_req_rise(output int t);
    while (conv_req) @(negedge clk);
    while (!conv_req) @(negedge clk);
    t = cyc;
  endtask

  initial begin
    int t0, t1, base, c0, r0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(!running && !conv_req && !fifo_push && !fifo_clear, "R1", "quiet in reset",
        {running, conv_req, fifo_push, fifo_clear}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!running && !conv_req && !fifo_push && !fifo_clear, "R1", "quiet after reset",
        {running, conv_req, fifo_push, fifo_clear}, 0);

    // R2 + R5: start by run bit, 24-bit period 0x010000
    wr(A_HI, 16'h0001);
    wr(A_LO, 16'h0000);
    expect_seq(0, 1, 0, 2'd0, 1'b0);
    wr(A_CTRL, ctrl(1, 0, 0, 2'd0, 2'd0));
    @(negedge clk);
    chk(running, "R2", "running after run write", running, 1);
    t0 = cyc;
    wait_req_rise(t1);
    chk(t1 - t0 == 65536, "R5", "first request delay 24-bit", t1 - t0, 65536);
    wait_pushes(2);
    wr(A_CTRL, ctrl(0, 0, 0, 2'd0, 2'd0));
    @(negedge clk);
    chk(!running, "R8", "running after stop", running, 0);
    r0 = nreq; base = npush;
    repeat (100) @(negedge clk);
    chk(nreq == r0 && npush == base, "R8", "activity after stop", nreq - r0 + npush - base, 0);

    // R4 R7 R11 R5: wrap over pairs 0..2, period 20
    wr(A_HI, 16'h0000);
    wr(A_LO, 16'd20);
    base = npush;
    expect_seq(0, 7, 2, 2'd2, 1'b1);
    wr(A_CTRL, ctrl(1, 0, 2, 2'd2, 2'b10));
    @(negedge clk);
    t0 = cyc;
    wait_req_rise(t1);
    chk(t1 - t0 == 20, "R5", "first request delay", t1 - t0, 20);
    chk(conv_range == 2'd2 && conv_diff, "R11", "range/diff outputs", {conv_range, conv_diff}, 5);
    t0 = t1;
    wait_req_rise(t1);
    chk(t1 - t0 == 20, "R5", "request spacing", t1 - t0, 20);
    wait_pushes(base + 14);
    wr(A_CTRL, ctrl(0, 0, 2, 2'd2, 2'b10));
    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R4", "pending expected pushes", sb_q.size(), 0);

    // R10: reconfigure while running, then rewrite unchanged
    base = npush;
    expect_seq(0, 2, 3, 2'd1, 1'b1);
    wr(A_CTRL, ctrl(1, 0, 3, 2'd1, 2'b01));
    wait_pushes(base + 4);
    c0 = nclr;
    sb_q.delete();
    expect_seq(0, 3, 3, 2'd3, 1'b1);
    wr(A_CTRL, ctrl(1, 0, 3, 2'd3, 2'b01));
    repeat (2) @(negedge clk);
    chk(nclr == c0 + 1, "R10", "clear pulses on change", nclr - c0, 1);
    chk(running, "R10", "running after reconfigure", running, 1);
    wait_pushes(base + 10);
    c0 = nclr;
    expect_seq(3, 2, 3, 2'd3, 1'b1);
    wr(A_CTRL, ctrl(1, 0, 3, 2'd3, 2'b01));
    repeat (4) @(negedge clk);
    chk(nclr == c0, "R10", "clear pulses on unchanged write", nclr - c0, 0);
    wait_pushes(base + 14);
    wr(A_CTRL, ctrl(0, 0, 3, 2'd3, 2'b01));
    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R10", "pending expected pushes", sb_q.size(), 0);

    // R6: slow converter, period 4, latency 30
    lat = 30;
    wr(A_LO, 16'd4);
    base = npush;
    expect_seq(0, 4, 1, 2'd0, 1'b0);
    wr(A_CTRL, ctrl(1, 0, 1, 2'd0, 2'd0));
    wait_pushes(base + 8);
    chk(gap_last == 34, "R6", "request spacing with slow converter", gap_last, 34);
    chk(overlaps == 0, "R6", "overlapping requests", overlaps, 0);
    wr(A_CTRL, ctrl(0, 0, 1, 2'd0, 2'd0));
    repeat (40) @(negedge clk);
    chk(sb_q.size() == 0, "R6", "pending expected pushes", sb_q.size(), 0);
    lat = 3;

    // R3: trigger disabled, then enabled
    wr(A_LO, 16'd20);
    wr(A_CTRL, ctrl(0, 0, 1, 2'd0, 2'd0));
    ext_trig_n = 1'b0;
    repeat (5) @(negedge clk);
    ext_trig_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(!running, "R3", "start with trigger disabled", running, 0);
    wr(A_CTRL, ctrl(0, 1, 1, 2'd0, 2'd0));
    base = npush;
    expect_seq(0, 2, 1, 2'd0, 1'b0);
    repeat (3) @(negedge clk);
    ext_trig_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(running, "R3", "start by trigger edge", running, 1);
    wait_pushes(base + 4);
    wr(A_CTRL, ctrl(0, 1, 1, 2'd0, 2'd0));
    ext_trig_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0 && !running, "R3", "pending pushes after trigger run", sb_q.size(), 0);

    // R9: FIFO full stops acquisition
    base = npush;
    expect_seq(0, 1, 0, 2'd0, 1'b0);
    wr(A_CTRL, ctrl(1, 0, 0, 2'd0, 2'd0));
    wait_pushes(base + 2);
    fifo_full = 1'b1;
    repeat (60) @(negedge clk);
    chk(!running, "R9", "running after full", running, 0);
    chk(npush == base + 2, "R9", "pushes while full", npush - base, 2);
    fifo_full = 1'b0;
    chk(sb_q.size() == 0, "R9", "pending expected pushes", sb_q.size(), 0);

    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule